// File: doc/BRIEF.md
# Open-Drain Display Link GPIO Port

This block gives software direct pin-level control of the two wires of a display identification link. Those wires are the serial clock and the serial data lines of a two-wire I2C bus. Each channel has a 32-bit register. Each line has an enable bit and a value bit in that register. A line is pulled low only when its enable bit is set and its value bit is zero. In every other case the block lets go of the line, and the external pull-up holds it high. After each register update, the channel waits for the lines to settle, samples them through a two-stage synchroniser, and writes the resolved clock and data levels into read-back bits. Software can then see its own drive, and also any target that holds the data line low.

The block has two channels. Channel 0 keeps its bit fields at base position 0, and every accepted write updates the bus. Channel 1 moves the same fields up by one bit. It only acts on a write when a mask bit is set and the byte strobes show that the write reached the enable byte. Writes with partial byte strobes are merged into the stored register first, and the update decision is made on the merged value. The transaction protocol is left to software.

Top module: `ddc_gpio_port`

## Requirements
- R1: For a channel with base b: bit b is the data value, bit b+1 is the clock value, bit b+16 is the data enable and bit b+17 is the clock enable. An update drives a line low exactly when its enable is 1 and its value is 0. Channel 0 uses b=0 and channel 1 uses b=1.
- R2: If a line's enable bit is 0, the line is released (its low-drive output is 0), whatever its value bit holds.
- R3: The clock low-drive output takes its new state on the clock edge that accepts the update. The data low-drive output takes its new state one edge later.
- R4: An update clears bits [11:8]. SETTLE_CYC+1 edges after the update edge (default 5), bit b+9 receives the synchronised clock level and bit b+8 the synchronised data level. The data level includes any target pulling the line low.
- R5: Bits [11:8] are read-only. Software write data has no effect on them.
- R6: On channel 0, any write with at least one byte strobe set is an update.
- R7: On channel 1, a write is an update only if bit 25 of the merged value is 1 and either strobe 2 is set, or strobe 0 is set while bit 17 or bit 18 of the merged value is 1. Otherwise the line outputs keep their state.
- R8: On channel 1, the strobed bytes are stored even when the write is not an update. The update test and the drive levels use the merged register value.
- R9: If a non-update write lands on the same edge as the read-back capture, both its data bytes and the captured level bits are kept.
- R10: After reset both registers read 0 and all four lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Channel addressed by the write |
| wr_be | input | 4 | Byte strobes of the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Channel shown on rd_data |
| rd_data | output | 32 | Register value of the selected channel |
| ddc_scl_in | input | 2 | Sensed clock line level, one per channel |
| ddc_sda_in | input | 2 | Sensed data line level, one per channel |
| ddc_scl_low | output | 2 | Pull clock line low, one per channel |
| ddc_sda_low | output | 2 | Pull data line low, one per channel |

## Verification
The read-back capture and a software write can land on the same clock edge. The bench provokes this by starting an update on channel 1 and then placing a non-updating write that only sets byte 3 exactly on the capture edge. It judges the result from the register value read one half-cycle later. That value must hold both the newly written byte and the sampled clock and data levels. The value read one cycle earlier must still show the level bits cleared.

// File: rtl/ddc_gpio_pkg.sv
package ddc_gpio_pkg;

    localparam int unsigned REG_W   = 32;
    localparam int unsigned BYTES   = REG_W / 8;
    localparam int unsigned CNT_W   = 8;
    localparam logic [REG_W-1:0] RB_MASK = 32'h0000_0F00;

    typedef struct packed {
        logic [REG_W-1:0] val;
        logic             scl_low;
        logic             sda_low;
        logic             sda_pend;
        logic             sda_stage;
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } chan_st_t;

endpackage

// File: rtl/ddc_line_sync.sv
module ddc_line_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe_d [STAGES];
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_comb begin
        pipe_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < STAGES; s++) begin
            if (!rst_n) pipe_q[s] <= '1;
            else        pipe_q[s] <= pipe_d[s];
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/ddc_gpio_chan.sv
module ddc_gpio_chan
    import ddc_gpio_pkg::*;
#(
    parameter int unsigned BASE       = 0,
    parameter bit          GATED      = 1'b0,
    parameter int unsigned MASK_BIT   = 25,
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BYTES-1:0] wr_be,
    input  logic [REG_W-1:0] wr_data,
    input  logic             scl_lvl,
    input  logic             sda_lvl,
    output logic [REG_W-1:0] reg_val,
    output logic             scl_low,
    output logic             sda_low
);
    localparam int unsigned DV = BASE;
    localparam int unsigned CV = BASE + 1;
    localparam int unsigned DE = BASE + 16;
    localparam int unsigned CE = BASE + 17;
    localparam int unsigned RD = BASE + 8;
    localparam int unsigned RC = BASE + 9;

    chan_st_t         s_d, s_q;
    logic [REG_W-1:0] merged;
    logic             upd;
    logic             cap;

    // byte merge; level bits stay under hardware control
    always_comb begin
        merged = s_q.val;
        for (int k = 0; k < BYTES; k++) begin
            if (wr_be[k]) merged[8*k +: 8] = wr_data[8*k +: 8];
        end
        merged = (merged & ~RB_MASK) | (s_q.val & RB_MASK);
    end

    generate
        if (GATED) begin : g_gated
            assign upd = wr_en && merged[MASK_BIT] &&
                         (wr_be[2] || (wr_be[0] && (merged[CE] || merged[DE])));
        end else begin : g_plain
            assign upd = wr_en && (|wr_be);
        end
    endgenerate

    assign cap = s_q.busy && (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (s_q.sda_stage) begin
            s_d.sda_low   = s_q.sda_pend;
            s_d.sda_stage = 1'b0;
        end
        if (wr_en) s_d.val = merged;
        if (s_q.busy) begin
            if (cap) begin
                s_d.val[RC] = scl_lvl;
                s_d.val[RD] = sda_lvl;
                s_d.busy    = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (upd) begin
            s_d.val       = merged & ~RB_MASK;
            s_d.scl_low   = merged[CE] & ~merged[CV];
            s_d.sda_pend  = merged[DE] & ~merged[DV];
            s_d.sda_stage = 1'b1;
            s_d.busy      = 1'b1;
            s_d.cnt       = CNT_W'(SETTLE_CYC);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reg_val = s_q.val;
    assign scl_low = s_q.scl_low;
    assign sda_low = s_q.sda_low;

    AST_SDA_LAGS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !s_q.sda_stage) |=> $stable(sda_low)); // R3

    AST_CLEAR_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> ((reg_val & RB_MASK) == '0)); // R4

    AST_LEVELS_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !upd && !cap) |=> $stable(reg_val[11:8])); // R5

    AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !upd && !s_q.sda_stage) |=> ($stable(scl_low) && $stable(sda_low))); // R7

    AST_RELEASE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !merged[CE]) |=> !scl_low); // R2
endmodule

// File: rtl/ddc_gpio_port.sv
module ddc_gpio_port
    import ddc_gpio_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SETTLE_CYC  = 4,
    parameter int unsigned MASK_BIT    = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [3:0]       wr_be,
    input  logic [31:0]      wr_data,
    input  logic             rd_sel,
    output logic [31:0]      rd_data,
    input  logic [1:0]       ddc_scl_in,
    input  logic [1:0]       ddc_sda_in,
    output logic [1:0]       ddc_scl_low,
    output logic [1:0]       ddc_sda_low
);
    localparam int unsigned NCH = 2;

    logic [NCH-1:0]   scl_sync, sda_sync;
    logic [REG_W-1:0] reg_val [NCH];

    ddc_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2*NCH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ddc_scl_in, ddc_sda_in}),
        .q     ({scl_sync, sda_sync})
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ddc_gpio_chan #(
            .BASE       (g),
            .GATED      (g != 0),
            .MASK_BIT   (MASK_BIT),
            .SETTLE_CYC (SETTLE_CYC)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_sel == 1'(g))),
            .wr_be   (wr_be),
            .wr_data (wr_data),
            .scl_lvl (scl_sync[g]),
            .sda_lvl (sda_sync[g]),
            .reg_val (reg_val[g]),
            .scl_low (ddc_scl_low[g]),
            .sda_low (ddc_sda_low[g])
        );
    end

    assign rd_data = reg_val[rd_sel];
endmodule

// File: tb/sim_ddc_gpio_port.sv
module sim_ddc_gpio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [1:0]  scl_in, sda_in, scl_low, sda_low;
    logic [1:0]  tgt_sda = '0;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign scl_in = ~scl_low;
    assign sda_in = ~(sda_low | tgt_sda);

    ddc_gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .ddc_scl_in(scl_in), .ddc_sda_in(sda_in),
        .ddc_scl_low(scl_low), .ddc_sda_low(sda_low)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic ch, output logic [31:0] v);
        rd_sel = ch;
        #1 v = rd_data;
    endtask

    // drive at negedge, accept on next posedge, return at the following negedge
    task automatic wr(input logic ch, input logic [3:0] be, input logic [31:0] d);
        wr_sel = ch; wr_be = be; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v); check("R10 ch0 reg", v, 32'h0);
        rd(1'b1, v); check("R10 ch1 reg", v, 32'h0);
        check("R10 lines", {28'h0, scl_low, sda_low}, 32'h0);
    endtask

    task automatic t_map();
        wr(1'b0, 4'hF, 32'h0003_0000); @(negedge clk);
        check("R1 R6 ch0 both low", {30'h0, scl_low[0], sda_low[0]}, 32'h3);
        wr(1'b0, 4'hF, 32'h0003_0003); @(negedge clk);
        check("R1 ch0 values high release", {30'h0, scl_low[0], sda_low[0]}, 32'h0);
        wr(1'b0, 4'hF, 32'h0002_0000); @(negedge clk);
        check("R2 data enable clear", {30'h0, scl_low[0], sda_low[0]}, 32'h2);
        wr(1'b0, 4'hF, 32'h0000_0000); @(negedge clk);
        check("R2 all released", {30'h0, scl_low[0], sda_low[0]}, 32'h0);
        settle();
    endtask

    task automatic t_order();
        wr(1'b0, 4'hF, 32'h0003_0000);
        check("R3 clock first", {30'h0, scl_low[0], sda_low[0]}, 32'h2);
        @(negedge clk);
        check("R3 data one edge later", {30'h0, scl_low[0], sda_low[0]}, 32'h3);
        settle();
    endtask

    task automatic t_readback();
        logic [31:0] v;
        tgt_sda[0] = 1'b1;
        wr(1'b0, 4'hF, 32'h0003_0003);
        rd(1'b0, v); check("R4 levels cleared", v, 32'h0003_0003);
        settle();
        rd(1'b0, v); check("R4 target holds data", v, 32'h0003_0203);
        tgt_sda[0] = 1'b0;
        wr(1'b0, 4'hF, 32'h0003_0001);
        settle();
        rd(1'b0, v); check("R4 clock driven low", v, 32'h0003_0101);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        wr(1'b0, 4'hF, 32'h0000_0000); settle();
        wr(1'b0, 4'h2, 32'h0000_0F00);
        rd(1'b0, v); check("R5 R6 single byte updates", v, 32'h0);
        settle();
        rd(1'b0, v); check("R5 level bits ignore data", v, 32'h0000_0300);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        wr(1'b1, 4'hF, 32'h0006_0000); settle();
        check("R7 no mask no drive", {30'h0, scl_low[1], sda_low[1]}, 32'h0);
        rd(1'b1, v); check("R8 stored without update", v, 32'h0006_0000);
        wr(1'b1, 4'hF, 32'h0206_0000); settle();
        check("R7 R1 masked write drives", {30'h0, scl_low[1], sda_low[1]}, 32'h3);
        wr(1'b1, 4'h8, 32'h0200_0000); settle();
        check("R7 byte3 only holds", {30'h0, scl_low[1], sda_low[1]}, 32'h3);
        rd(1'b1, v); check("R4 ch1 both low", v, 32'h0206_0000);
    endtask

    task automatic t_partial();
        wr(1'b1, 4'h1, 32'h0000_0006); settle();
        check("R8 byte0 uses stored mask", {30'h0, scl_low[1], sda_low[1]}, 32'h0);
        wr(1'b1, 4'h4, 32'h0000_0000); settle();
        wr(1'b1, 4'h1, 32'h0000_0000); settle();
        check("R7 byte0 no enable no drive", {30'h0, scl_low[1], sda_low[1]}, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        tgt_sda[1] = 1'b1;
        wr(1'b1, 4'hF, 32'h0206_0006);
        repeat (4) @(negedge clk);
        rd(1'b1, v); check("R9 before capture", v, 32'h0206_0006);
        wr(1'b1, 4'h8, 32'h8200_0000);
        rd(1'b1, v); check("R9 write and capture", v, 32'h8206_0406);
        tgt_sda[1] = 1'b0;
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_order();
        t_readback();
        t_readonly();
        t_gate();
        t_partial();
        t_same_cycle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #4000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule